// File: doc/BRIEF.md
# Two-Phase Interleaved Buck Gate Sequencer

This block is the digital sequencer of a two-phase synchronous step-down controller. An internal oscillator divides the system clock into a pair of phase clocks, one for each phase. The two phase clocks sit half a phase period apart. For each phase, the block drives a high-side and a low-side gate enable. The analog parts are modelled as digital inputs: the PWM comparator trip, the switch-node-low sense, the low-gate-low sense, and the reverse-current and overcurrent flags.

Modulation is leading-edge. A phase clock ends the high-side pulse and starts the low-side pulse. A comparator trip ends the low-side pulse and starts the next high-side pulse. Every hand-over between the two switches waits for the matching sense input, with a timeout as a backstop. The low side always stays on for a minimum number of cycles. A reverse-current flag blanks the phase until its next clock. An overcurrent flag forces every low side on until the sensed current reaches zero, and then a one-cycle restart request is issued. In light-load mode, phase A is parked with both of its gates off.

Top module: `ilb_gate_seq`

## Requirements
- R1: After reset, phase A's clock pulses first, once the oscillator counter has run `OSC_CYC` cycles. The phase clocks then alternate. Each phase clock pulses once every `2*OSC_CYC` cycles, and phase B pulses `OSC_CYC` cycles after phase A. Index 0 of every per-phase vector is phase A and index 1 is phase B.
- R2: The high side of a phase turns off one cycle after that phase's clock pulse. While the trip input stays low, the high side never turns on.
- R3: After the high side turns off, the low side turns on one cycle after the switch-node-low input is sampled high. The high side and the low side are both off for `min(s, SENSE_TMO-1)+1` cycles, where `s` is the delay in cycles before the switch-node-low input goes high.
- R4: After the low side turns off, the high side turns on one cycle after the low-gate-low input is sampled high. Both gates are off for `min(g, SENSE_TMO-1)+1` cycles, where `g` is the delay in cycles before the low-gate-low input goes high.
- R5: The high side and the low side of the same phase are never on in the same cycle.
- R6: Each low-side pulse lasts at least `MIN_LS` cycles. If the trip input is raised `d` cycles into the pulse and held, the pulse lasts `max(d+1, MIN_LS)` cycles.
- R7: A reverse-current flag seen while the low side is on turns the low side off in the next cycle. Both gates of that phase then stay off, whatever the trip input does, until the phase's next clock pulse. The low side turns on one cycle after that pulse.
- R8: An overcurrent flag on either phase forces every high side off and every enabled low side on within three cycles. This holds until the zero-current input is sampled high. The restart output then pulses high for exactly one cycle.
- R9: While the light-load input is high, both gates of phase A are off from the next cycle on. When the input goes low, phase A resumes switching.
- R10: If a sense input never arrives, the sequencer advances after `SENSE_TMO` cycles of waiting.
- R11: During reset and after it, every gate enable and the restart output are low until the first phase clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| trip_i | input | 2 | PWM comparator trip per phase |
| swlow_i | input | 2 | Switch node below the low-side turn-on level, per phase |
| lglow_i | input | 2 | Low-side gate pin below the high-side turn-on level, per phase |
| rev_i | input | 2 | Reverse current seen in the low side, per phase |
| oc_i | input | 2 | Overcurrent flag per phase |
| izero_i | input | 1 | Sensed current has returned to zero |
| lite_i | input | 1 | Light-load mode, parks phase A |
| hs_o | output | 2 | High-side gate enable per phase |
| ls_o | output | 2 | Low-side gate enable per phase |
| tick_o | output | 2 | Phase clock pulses |
| restart_o | output | 1 | One-cycle soft-start restart request |

## Verification
The bench varies the sense and trip delays around the timeout and minimum-on boundaries. Wrong clamping would show up there as a dead-time or low-side length that is off by one, or as a hang while waiting on a sense input. A reverse-current flag is raised early in a low-side pulse, and a trip is held high during the blank that follows. A design that resumes on the trip, instead of waiting for the next phase clock, turns the high side on too soon. Overcurrent is injected while both phases are switching, and the bench checks that the restart request is a single pulse. Phase A is driven with every input active while light-load mode is on, so any leakage of its gates is seen.

// File: rtl/ilb_pkg.sv
package ilb_pkg;

    localparam int NPH  = 2;
    localparam int PH_A = 0;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LOW  = 3'd1,
        PH_DTHL = 3'd2,
        PH_HIGH = 3'd3,
        PH_DTLH = 3'd4
    } ph_state_e;

    typedef struct packed {
        logic trip;
        logic swlow;
        logic lglow;
        logic rev;
    } ph_sense_t;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilb_osc.sv
module ilb_osc
    import ilb_pkg::*;
#(
    parameter int OSC_CYC = 20
) (
    input  logic           clk_i,
    input  logic           rst_i,
    output logic [NPH-1:0] tick_o
);
    localparam int OW = $clog2(OSC_CYC);
    localparam logic [OW-1:0] LAST = OW'(OSC_CYC - 1);

    logic [OW-1:0] cnt_q;
    logic          sel_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + OW'(1);
            if (wrap) sel_q <= ~sel_q;
        end
    end

    // Alternate oscillator wraps go to alternate phases.
    assign tick_o[0] = wrap & ~sel_q;
    assign tick_o[1] = wrap &  sel_q;

endmodule

// File: rtl/ilb_fault.sv
module ilb_fault
    import ilb_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NPH-1:0] oc_i,
    input  logic           izero_i,
    output logic           fault_o,
    output logic           restart_o
);
    logic fault_q, restart_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fault_q   <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            if (!fault_q && (|oc_i)) fault_q <= 1'b1;
            else if (fault_q && izero_i) fault_q <= 1'b0;
            restart_q <= fault_q && izero_i;
        end
    end

    assign fault_o   = fault_q;
    assign restart_o = restart_q;

endmodule

// File: rtl/ilb_phase.sv
module ilb_phase
    import ilb_pkg::*;
#(
    parameter int MIN_LS    = 6,
    parameter int SENSE_TMO = 8
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      tick_i,
    input  logic      disable_i,
    input  logic      force_i,
    input  ph_sense_t sense_i,
    output gate_t     gate_o
);
    localparam int LIM = imax(MIN_LS, SENSE_TMO);
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] LS_LAST  = CW'(MIN_LS - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(SENSE_TMO - 1);
    localparam logic [CW-1:0] CMAX     = CW'(LIM);

    ph_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        if (disable_i) begin
            st_d = PH_IDLE;
        end else if (force_i) begin
            // leave a blank cycle when the high side was on
            st_d = (st_q == PH_HIGH) ? PH_IDLE : PH_LOW;
        end else begin
            unique case (st_q)
                PH_IDLE: if (tick_i) st_d = PH_LOW;
                PH_LOW: begin
                    if (sense_i.rev) st_d = PH_IDLE;
                    else if (sense_i.trip && cnt_q >= LS_LAST) st_d = PH_DTHL;
                end
                PH_DTHL: begin
                    if (tick_i) st_d = PH_DTLH;
                    else if (sense_i.lglow || cnt_q >= TMO_LAST) st_d = PH_HIGH;
                end
                PH_HIGH: if (tick_i) st_d = PH_DTLH;
                PH_DTLH: if (sense_i.swlow || cnt_q >= TMO_LAST) st_d = PH_LOW;
                default: st_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != st_q) cnt_q <= '0;
            else if (cnt_q != CMAX) cnt_q <= cnt_q + CW'(1);
        end
    end

    assign gate_o.hs = (st_q == PH_HIGH);
    assign gate_o.ls = (st_q == PH_LOW);

endmodule

// File: rtl/ilb_gate_seq.sv
module ilb_gate_seq
    import ilb_pkg::*;
#(
    parameter int OSC_CYC   = 20,
    parameter int MIN_LS    = 6,
    parameter int SENSE_TMO = 8
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [NPH-1:0] trip_i,
    input  logic [NPH-1:0] swlow_i,
    input  logic [NPH-1:0] lglow_i,
    input  logic [NPH-1:0] rev_i,
    input  logic [NPH-1:0] oc_i,
    input  logic           izero_i,
    input  logic           lite_i,
    output logic [NPH-1:0] hs_o,
    output logic [NPH-1:0] ls_o,
    output logic [NPH-1:0] tick_o,
    output logic           restart_o
);
    logic [NPH-1:0] tick;
    logic           fault;

    ilb_osc #(.OSC_CYC(OSC_CYC)) osc_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    ilb_fault flt_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .oc_i      (oc_i),
        .izero_i   (izero_i),
        .fault_o   (fault),
        .restart_o (restart_o)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        ph_sense_t sn;
        gate_t     gt;
        logic      park;

        assign sn   = '{trip: trip_i[p], swlow: swlow_i[p], lglow: lglow_i[p], rev: rev_i[p]};
        assign park = (p == PH_A) ? lite_i : 1'b0;

        ilb_phase #(.MIN_LS(MIN_LS), .SENSE_TMO(SENSE_TMO)) ph_i (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .tick_i    (tick[p]),
            .disable_i (park),
            .force_i   (fault),
            .sense_i   (sn),
            .gate_o    (gt)
        );

        assign hs_o[p] = gt.hs;
        assign ls_o[p] = gt.ls;
    end

    assign tick_o = tick;

endmodule

// File: rtl/ilb_gate_seq_chk.sv
module ilb_gate_seq_chk
    import ilb_pkg::*;
(
    input logic           clk_i,
    input logic           rst_i,
    input logic           lite_i,
    input logic [NPH-1:0] hs_o,
    input logic [NPH-1:0] ls_o,
    input logic           restart_o
);
    // R5
    excl_gates_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hs_o & ls_o) == '0);

    // R3
    ls_after_hs_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ls_o & ~$past(ls_o) & $past(hs_o)) == '0);

    // R4
    hs_after_ls_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hs_o & ~$past(hs_o) & $past(ls_o)) == '0);

    // R9
    lite_parks_a_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(lite_i) |-> (hs_o[PH_A] == 1'b0 && ls_o[PH_A] == 1'b0));

    // R8
    restart_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o |=> !restart_o);

endmodule

bind ilb_gate_seq ilb_gate_seq_chk chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .lite_i    (lite_i),
    .hs_o      (hs_o),
    .ls_o      (ls_o),
    .restart_o (restart_o)
);

// File: tb/ilb_gate_seq_tb_top.sv
module ilb_gate_seq_tb_top;
    localparam int OSC_CYC   = 20;
    localparam int MIN_LS    = 6;
    localparam int SENSE_TMO = 8;

    // {swlow delay, trip delay, lglow delay, exp dead lh, exp low len, exp dead hl}
    localparam int NV = 5;
    localparam int VEC [0:NV-1][0:5] = '{
        '{0,  0,  0, 1, 6,  1},
        '{3,  8,  2, 4, 9,  3},
        '{10, 2, 12, 8, 6,  8},
        '{7,  5,  7, 8, 6,  8},
        '{1, 12,  4, 2, 13, 5}
    };

    logic       clk_i = 1'b0;
    logic       rst_i = 1'b1;
    logic [1:0] trip_i = '0, swlow_i = '0, lglow_i = '0, rev_i = '0, oc_i = '0;
    logic       izero_i = 1'b0, lite_i = 1'b1;
    logic [1:0] hs_o, ls_o, tick_o;
    logic       restart_o;

    int checks = 0, fails = 0, cyc = 0;
    int both_cnt = 0, a_act = 0;
    logic a_watch = 1'b0, done = 1'b0;

    always #4 clk_i = ~clk_i;

    ilb_gate_seq #(.OSC_CYC(OSC_CYC), .MIN_LS(MIN_LS), .SENSE_TMO(SENSE_TMO)) dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .trip_i(trip_i), .swlow_i(swlow_i),
        .lglow_i(lglow_i), .rev_i(rev_i), .oc_i(oc_i), .izero_i(izero_i),
        .lite_i(lite_i), .hs_o(hs_o), .ls_o(ls_o), .tick_o(tick_o),
        .restart_o(restart_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nstep();
        @(negedge clk_i);
    endtask

    always @(negedge clk_i) begin
        if (!rst_i) begin
            if ((hs_o & ls_o) != 2'b00) both_cnt++;
            if (a_watch && (hs_o[0] || ls_o[0])) a_act++;
        end
    end

    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, g;
        int bad_both, bad_hs, bad_ls;
        repeat (4) nstep();
        chk("R11 hs during reset", int'(hs_o), 0);
        rst_i = 1'b0;
        nstep();
        chk("R11 hs after reset", int'(hs_o), 0);
        chk("R11 ls after reset", int'(ls_o), 0);
        chk("R11 restart after reset", int'(restart_o), 0);

        // R1: phase clock spacing
        g = 0;
        while (!tick_o[0] && g < 200) begin nstep(); g++; end
        n = 0;
        do begin nstep(); n++; end while (!tick_o[1] && n < 200);
        chk("R1 A to B clock spacing", n, OSC_CYC);
        n = 0;
        do begin nstep(); n++; end while (!tick_o[0] && n < 200);
        chk("R1 B to A clock spacing", n, OSC_CYC);

        // bring phase B into its high state, phase A fully stimulated but parked
        a_watch = 1'b1;
        trip_i = 2'b11; swlow_i = 2'b11; lglow_i = 2'b11;
        g = 0;
        while (!hs_o[1] && g < 300) begin nstep(); g++; end

        // vector table: R3, R4, R6, R10
        for (int e = 0; e < NV; e++) begin
            trip_i[1] = 1'b0; swlow_i[1] = 1'b0; lglow_i[1] = 1'b0;
            g = 0;
            while (hs_o[1] && g < 200) begin nstep(); g++; end
            n = 0;
            while (!ls_o[1] && n < 50) begin
                if (n == VEC[e][0]) swlow_i[1] = 1'b1;
                n++; nstep();
            end
            chk($sformatf("R3 R10 dead before low, vec %0d", e), n, VEC[e][3]);
            swlow_i[1] = 1'b0;
            n = 0;
            while (ls_o[1] && n < 50) begin
                if (n == VEC[e][1]) trip_i[1] = 1'b1;
                n++; nstep();
            end
            chk($sformatf("R6 low length, vec %0d", e), n, VEC[e][4]);
            trip_i[1] = 1'b0;
            n = 0;
            while (!hs_o[1] && n < 50) begin
                if (n == VEC[e][2]) lglow_i[1] = 1'b1;
                n++; nstep();
            end
            chk($sformatf("R4 R10 dead before high, vec %0d", e), n, VEC[e][5]);
            lglow_i[1] = 1'b0;
        end
        a_watch = 1'b0;
        chk("R9 phase A parked in light load", a_act, 0);

        // R7: reverse current blanks phase B until its next clock
        swlow_i[1] = 1'b1;
        g = 0;
        while (!ls_o[1] && g < 200) begin nstep(); g++; end
        rev_i[1] = 1'b1;
        nstep();
        rev_i[1] = 1'b0;
        chk("R7 low side dropped on reverse current", int'({hs_o[1], ls_o[1]}), 0);
        trip_i[1] = 1'b1; lglow_i[1] = 1'b1;
        bad_both = 0; g = 0;
        while (!tick_o[1] && g < 200) begin
            if (hs_o[1] || ls_o[1]) bad_both++;
            nstep(); g++;
        end
        chk("R7 phase blank until clock", bad_both, 0);
        nstep();
        chk("R7 low side after clock", int'(ls_o[1]), 1);

        // R2: high side ends at the phase clock
        g = 0;
        while (!hs_o[1] && g < 200) begin nstep(); g++; end
        g = 0;
        while (!(tick_o[1] && hs_o[1]) && g < 200) begin nstep(); g++; end
        nstep();
        chk("R2 high off after clock", int'(hs_o[1]), 0);

        // R2: no trip, no high side
        trip_i[1] = 1'b0;
        g = 0;
        while (!ls_o[1] && g < 200) begin nstep(); g++; end
        bad_hs = 0; bad_ls = 0;
        for (int i = 0; i < 2 * OSC_CYC + 5; i++) begin
            if (hs_o[1]) bad_hs++;
            if (!ls_o[1]) bad_ls++;
            nstep();
        end
        chk("R2 high stays off without trip", bad_hs, 0);
        chk("R6 low held without trip", bad_ls, 0);

        // R9: leaving light load revives phase A
        lite_i = 1'b0;
        trip_i = 2'b11;
        n = 0;
        for (int i = 0; i < 100; i++) begin
            if (ls_o[0] || hs_o[0]) n = 1;
            nstep();
        end
        chk("R9 phase A switches after light load", n, 1);

        // R8: overcurrent
        oc_i[0] = 1'b1;
        nstep();
        oc_i[0] = 1'b0;
        nstep(); nstep();
        chk("R8 highs forced off", int'(hs_o), 0);
        chk("R8 lows forced on", int'(ls_o), 3);
        bad_both = 0;
        for (int i = 0; i < 30; i++) begin
            if (hs_o != 2'b00 || ls_o != 2'b11 || restart_o) bad_both++;
            nstep();
        end
        chk("R8 forced state held", bad_both, 0);
        izero_i = 1'b1;
        nstep();
        izero_i = 1'b0;
        chk("R8 restart pulse", int'(restart_o), 1);
        nstep();
        chk("R8 restart single cycle", int'(restart_o), 0);

        chk("R5 high and low never together", both_cnt, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule